// File: doc/BRIEF.md
# Trap Return State Updater

This block resolves the two privileged return instructions of a RISC-V style hart, the machine return and the supervisor return, with optional hypervisor support. For each accepted return it checks privilege and trap-control permissions and the alignment of the saved return address. It then either reports an exception with its cause or produces the whole post-return state: the new privilege level, the new virtualization flag, the return PC and the updated interrupt-enable stack fields.

The surrounding pipeline presents the current hart state and pulses `retValid` together with `retIsMachine`. One clock edge later, `respValid` pulses and every result output holds the outcome. When the return is rejected, the status outputs repeat the inputs unchanged. The owner of the status registers can therefore write the outputs back on every response without a separate branch for the exception case.

Privilege encoding throughout is U = 0, S = 1, M = 3. The cause codes are 0 for a misaligned instruction address, 2 for an illegal instruction and 22 for a virtual-instruction fault.

Top module: `trap_return_unit`

## Requirements
- R1: After reset, `respValid` and `excValid` are 0, `newPriv` is 3 (M) and `newVirt` is 0.
- R2: A supervisor return (`retIsMachine`=0) issued at privilege U raises cause 2.
- R3: A supervisor return issued below M with `stTsr`=1 raises cause 2. At privilege M, `stTsr` has no effect. This check takes priority over the virtual trap check of R4.
- R4: A supervisor return with `curVirt`=1, `hsVtsr`=1 and no earlier fault raises cause 22.
- R5: When `HAS_COMPRESSED`=0, a return whose selected saved PC (`mepc` or `sepc`) has a nonzero bit [1:0] raises cause 0. This check follows the privilege-level check and comes before the R3 and R4 checks.
- R6: A successful supervisor return sets `newPriv`={0,`stSpp`}, `nxtSie`=`stSpie`, `nxtSpie`=1, `nxtSpp`=0, `nxtMprv`=0 and `retPc`=`sepc`.
- R7: On a successful supervisor return with `curVirt`=0, `newVirt`=`hsSpv` and `nxtSpv`=0. With `curVirt`=1, `newVirt` stays 1 and `nxtSpv` equals `hsSpv`.
- R8: A machine return issued at a privilege other than M raises cause 2.
- R9: A successful machine return sets `newPriv`=`stMpp`, `nxtMie`=`stMpie`, `nxtMpie`=1, `nxtMpp`=0 (or 3 when `HAS_USER`=0), `nxtMpv`=0 and `retPc`=`mepc`.
- R10: On a successful machine return, `newVirt` = `stMpv` AND (`stMpp` != 3).
- R11: A successful machine return clears `nxtMprv` only when `stMpp` != 3. Otherwise `nxtMprv` equals `stMprv`.
- R12: On an exception, every `nxt*` output equals its input, `newPriv`=`curPriv`, `newVirt`=`curVirt` and `retPc`=0.
- R13: `respValid` is high for exactly the one cycle after each `retValid` cycle. `excValid` is high in that cycle only for a rejected return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retValid | input | 1 | A return instruction is accepted this cycle |
| retIsMachine | input | 1 | 1 = machine return, 0 = supervisor return |
| curPriv | input | 2 | Current privilege (U=0, S=1, M=3) |
| curVirt | input | 1 | Virtualization currently active |
| mepc | input | XLEN | Machine saved exception PC |
| sepc | input | XLEN | Supervisor saved exception PC |
| stMie | input | 1 | Machine interrupt enable |
| stMpie | input | 1 | Machine previous interrupt enable |
| stSie | input | 1 | Supervisor interrupt enable |
| stSpie | input | 1 | Supervisor previous interrupt enable |
| stSpp | input | 1 | Supervisor previous privilege |
| stMpp | input | 2 | Machine previous privilege |
| stMpv | input | 1 | Machine previous virtualization |
| stMprv | input | 1 | Modify-privilege bit |
| stTsr | input | 1 | Trap supervisor return |
| hsSpv | input | 1 | Hypervisor supervisor previous virtualization |
| hsVtsr | input | 1 | Virtual trap supervisor return |
| respValid | output | 1 | Result valid (one cycle after retValid) |
| excValid | output | 1 | Return rejected with an exception |
| excCause | output | 5 | Exception cause code |
| newPriv | output | 2 | Privilege after the return |
| newVirt | output | 1 | Virtualization after the return |
| retPc | output | XLEN | Return target PC, 0 on exception |
| nxtMie | output | 1 | Updated machine interrupt enable |
| nxtMpie | output | 1 | Updated machine previous interrupt enable |
| nxtSie | output | 1 | Updated supervisor interrupt enable |
| nxtSpie | output | 1 | Updated supervisor previous interrupt enable |
| nxtSpp | output | 1 | Updated supervisor previous privilege |
| nxtMpp | output | 2 | Updated machine previous privilege |
| nxtMpv | output | 1 | Updated machine previous virtualization |
| nxtMprv | output | 1 | Updated modify-privilege bit |
| nxtSpv | output | 1 | Updated hypervisor previous virtualization |

## Verification
The bench builds the block with XLEN=32, HAS_HYP=1, HAS_USER=1 and HAS_COMPRESSED=0. Turning compressed support off makes the misaligned-PC fault reachable, so its priority against the trap-control checks can be exercised. Enabling the hypervisor option brings the virtual trap check and the SPV-based virtualization restore within reach. With user mode present, the stacked MPP returns to U after a machine return.

// File: rtl/trap_ret_pkg.sv
package trap_ret_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  localparam int CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_VIRTINST = 5'd22;

  // Strobes from control to datapath
  typedef struct packed {
    logic               fire;
    logic               commit;
    logic               isMachine;
    logic               raise;
    logic [CAUSE_W-1:0] cause;
  } ret_strobe_t;

endpackage

// File: rtl/trap_ret_ctrl.sv
module trap_ret_ctrl
  import trap_ret_pkg::*;
#(
  parameter bit HAS_HYP        = 1'b1,
  parameter bit HAS_COMPRESSED = 1'b0
) (
  input  logic        retValid,
  input  logic        retIsMachine,
  input  logic [1:0]  curPriv,
  input  logic        curVirt,
  input  logic [1:0]  mepcLow,
  input  logic [1:0]  sepcLow,
  input  logic        stTsr,
  input  logic        hsVtsr,
  output ret_strobe_t strobe
);

  logic [1:0] selLow;
  logic       alignFault;
  logic       raise;
  logic [CAUSE_W-1:0] cause;

  assign selLow = retIsMachine ? mepcLow : sepcLow;

  generate
    if (HAS_COMPRESSED) begin : g_rvc
      assign alignFault = 1'b0;
    end else begin : g_norvc
      assign alignFault = |selLow;
    end
  endgenerate

  // Ordered permission checks
  always_comb begin
    raise = 1'b0;
    cause = CAUSE_ILLEGAL;
    if (retIsMachine) begin
      if (curPriv != PRIV_M) begin
        raise = 1'b1;
        cause = CAUSE_ILLEGAL;
      end else if (alignFault) begin
        raise = 1'b1;
        cause = CAUSE_MISALIGN;
      end
    end else begin
      if (curPriv == PRIV_U || curPriv == PRIV_RSV) begin
        raise = 1'b1;
        cause = CAUSE_ILLEGAL;
      end else if (alignFault) begin
        raise = 1'b1;
        cause = CAUSE_MISALIGN;
      end else if (stTsr && curPriv != PRIV_M) begin
        raise = 1'b1;
        cause = CAUSE_ILLEGAL;
      end else if (HAS_HYP && curVirt && hsVtsr) begin
        raise = 1'b1;
        cause = CAUSE_VIRTINST;
      end
    end
  end

  always_comb begin
    strobe.fire      = retValid;
    strobe.isMachine = retIsMachine;
    strobe.raise     = retValid && raise;
    strobe.commit    = retValid && !raise;
    strobe.cause     = cause;
  end

endmodule

// File: rtl/trap_ret_datapath.sv
module trap_ret_datapath
  import trap_ret_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter bit HAS_HYP  = 1'b1,
  parameter bit HAS_USER = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ret_strobe_t        strobe,
  input  logic [1:0]         curPriv,
  input  logic               curVirt,
  input  logic [XLEN-1:0]    mepc,
  input  logic [XLEN-1:0]    sepc,
  input  logic               stMie,
  input  logic               stMpie,
  input  logic               stSie,
  input  logic               stSpie,
  input  logic               stSpp,
  input  logic [1:0]         stMpp,
  input  logic               stMpv,
  input  logic               stMprv,
  input  logic               hsSpv,
  output logic               respValid,
  output logic               excValid,
  output logic [CAUSE_W-1:0] excCause,
  output logic [1:0]         newPriv,
  output logic               newVirt,
  output logic [XLEN-1:0]    retPc,
  output logic               nxtMie,
  output logic               nxtMpie,
  output logic               nxtSie,
  output logic               nxtSpie,
  output logic               nxtSpp,
  output logic [1:0]         nxtMpp,
  output logic               nxtMpv,
  output logic               nxtMprv,
  output logic               nxtSpv
);

  localparam logic [1:0] MPP_AFTER = HAS_USER ? PRIV_U : PRIV_M;

  logic [1:0]      dPriv, dMpp;
  logic            dVirt, dMie, dMpie, dSie, dSpie, dSpp, dMpv, dMprv, dSpv;
  logic [XLEN-1:0] dPc;
  logic            mretVirt;

  generate
    if (HAS_HYP) begin : g_hyp
      assign mretVirt = stMpv && (stMpp != PRIV_M);
    end else begin : g_nohyp
      assign mretVirt = 1'b0;
    end
  endgenerate

  always_comb begin
    dPriv = curPriv;
    dVirt = curVirt;
    dPc   = '0;
    dMie  = stMie;
    dMpie = stMpie;
    dSie  = stSie;
    dSpie = stSpie;
    dSpp  = stSpp;
    dMpp  = stMpp;
    dMpv  = stMpv;
    dMprv = stMprv;
    dSpv  = hsSpv;
    if (strobe.commit) begin
      if (strobe.isMachine) begin
        dPriv = stMpp;
        dVirt = mretVirt;
        dMie  = stMpie;
        dMpie = 1'b1;
        dMpp  = MPP_AFTER;
        dMpv  = 1'b0;
        if (stMpp != PRIV_M) dMprv = 1'b0;
        dPc   = mepc;
      end else begin
        dPriv = {1'b0, stSpp};
        dSie  = stSpie;
        dSpie = 1'b1;
        dSpp  = 1'b0;
        dMprv = 1'b0;
        dPc   = sepc;
        if (!HAS_HYP) begin
          dVirt = 1'b0;
        end else if (!curVirt) begin
          dVirt = hsSpv;
          dSpv  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      excValid  <= 1'b0;
      excCause  <= '0;
      newPriv   <= PRIV_M;
      newVirt   <= 1'b0;
      retPc     <= '0;
      nxtMie    <= 1'b0;
      nxtMpie   <= 1'b0;
      nxtSie    <= 1'b0;
      nxtSpie   <= 1'b0;
      nxtSpp    <= 1'b0;
      nxtMpp    <= 2'd0;
      nxtMpv    <= 1'b0;
      nxtMprv   <= 1'b0;
      nxtSpv    <= 1'b0;
    end else begin
      respValid <= strobe.fire;
      excValid  <= strobe.raise;
      excCause  <= strobe.raise ? strobe.cause : '0;
      newPriv   <= dPriv;
      newVirt   <= dVirt;
      retPc     <= dPc;
      nxtMie    <= dMie;
      nxtMpie   <= dMpie;
      nxtSie    <= dSie;
      nxtSpie   <= dSpie;
      nxtSpp    <= dSpp;
      nxtMpp    <= dMpp;
      nxtMpv    <= dMpv;
      nxtMprv   <= dMprv;
      nxtSpv    <= dSpv;
    end
  end

  // Checks
  assert_mret_needs_m_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && strobe.isMachine && curPriv != PRIV_M)
      |=> (excValid && excCause == CAUSE_ILLEGAL));

  assert_sret_low_priv_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && !strobe.isMachine && curPriv == PRIV_U)
      |=> (excValid && excCause == CAUSE_ILLEGAL));

  assert_exc_keeps_state_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && strobe.raise)
      |=> (nxtMie == $past(stMie) && nxtSie == $past(stSie) &&
           nxtMprv == $past(stMprv) && newPriv == $past(curPriv) && retPc == '0));

  assert_mret_stack_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && strobe.isMachine)
      |=> (nxtMpie && !nxtMpv && newPriv == $past(stMpp) && retPc == $past(mepc)));

  assert_sret_stack_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !strobe.isMachine)
      |=> (nxtSpie && !nxtSpp && !nxtMprv && retPc == $past(sepc)));

  assert_mprv_kept_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && strobe.isMachine && stMpp == PRIV_M)
      |=> (nxtMprv == $past(stMprv) && !newVirt));

  assert_resp_pulse_R13: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |=> respValid);

  assert_exc_only_on_resp_R13: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> respValid);

endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trap_ret_pkg::*;
#(
  parameter int XLEN           = 32,
  parameter bit HAS_HYP        = 1'b1,
  parameter bit HAS_USER       = 1'b1,
  parameter bit HAS_COMPRESSED = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               retValid,
  input  logic               retIsMachine,
  input  logic [1:0]         curPriv,
  input  logic               curVirt,
  input  logic [XLEN-1:0]    mepc,
  input  logic [XLEN-1:0]    sepc,
  input  logic               stMie,
  input  logic               stMpie,
  input  logic               stSie,
  input  logic               stSpie,
  input  logic               stSpp,
  input  logic [1:0]         stMpp,
  input  logic               stMpv,
  input  logic               stMprv,
  input  logic               stTsr,
  input  logic               hsSpv,
  input  logic               hsVtsr,
  output logic               respValid,
  output logic               excValid,
  output logic [4:0]         excCause,
  output logic [1:0]         newPriv,
  output logic               newVirt,
  output logic [XLEN-1:0]    retPc,
  output logic               nxtMie,
  output logic               nxtMpie,
  output logic               nxtSie,
  output logic               nxtSpie,
  output logic               nxtSpp,
  output logic [1:0]         nxtMpp,
  output logic               nxtMpv,
  output logic               nxtMprv,
  output logic               nxtSpv
);

  ret_strobe_t strobe;

  trap_ret_ctrl #(
    .HAS_HYP(HAS_HYP),
    .HAS_COMPRESSED(HAS_COMPRESSED)
  ) u_ctrl (
    .retValid(retValid),
    .retIsMachine(retIsMachine),
    .curPriv(curPriv),
    .curVirt(curVirt),
    .mepcLow(mepc[1:0]),
    .sepcLow(sepc[1:0]),
    .stTsr(stTsr),
    .hsVtsr(hsVtsr),
    .strobe(strobe)
  );

  trap_ret_datapath #(
    .XLEN(XLEN),
    .HAS_HYP(HAS_HYP),
    .HAS_USER(HAS_USER)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .curPriv(curPriv),
    .curVirt(curVirt),
    .mepc(mepc),
    .sepc(sepc),
    .stMie(stMie),
    .stMpie(stMpie),
    .stSie(stSie),
    .stSpie(stSpie),
    .stSpp(stSpp),
    .stMpp(stMpp),
    .stMpv(stMpv),
    .stMprv(stMprv),
    .hsSpv(hsSpv),
    .respValid(respValid),
    .excValid(excValid),
    .excCause(excCause),
    .newPriv(newPriv),
    .newVirt(newVirt),
    .retPc(retPc),
    .nxtMie(nxtMie),
    .nxtMpie(nxtMpie),
    .nxtSie(nxtSie),
    .nxtSpie(nxtSpie),
    .nxtSpp(nxtSpp),
    .nxtMpp(nxtMpp),
    .nxtMpv(nxtMpv),
    .nxtMprv(nxtMprv),
    .nxtSpv(nxtSpv)
  );

endmodule

// File: tb/trap_return_unit_bench.sv
module trap_return_unit_bench;

  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic retValid = 1'b0, retIsMachine = 1'b0;
  logic [1:0] curPriv = 2'd3;
  logic curVirt = 1'b0;
  logic [XLEN-1:0] mepc = '0, sepc = '0;
  logic stMie = 0, stMpie = 0, stSie = 0, stSpie = 0, stSpp = 0;
  logic [1:0] stMpp = 2'd0;
  logic stMpv = 0, stMprv = 0, stTsr = 0, hsSpv = 0, hsVtsr = 0;
  logic respValid, excValid, newVirt;
  logic [4:0] excCause;
  logic [1:0] newPriv, nxtMpp;
  logic [XLEN-1:0] retPc;
  logic nxtMie, nxtMpie, nxtSie, nxtSpie, nxtSpp, nxtMpv, nxtMprv, nxtSpv;

  int checkCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  trap_return_unit #(
    .XLEN(XLEN), .HAS_HYP(1'b1), .HAS_USER(1'b1), .HAS_COMPRESSED(1'b0)
  ) u_trap_return_unit (
    .clk(clk), .rstN(rstN), .retValid(retValid), .retIsMachine(retIsMachine),
    .curPriv(curPriv), .curVirt(curVirt), .mepc(mepc), .sepc(sepc),
    .stMie(stMie), .stMpie(stMpie), .stSie(stSie), .stSpie(stSpie),
    .stSpp(stSpp), .stMpp(stMpp), .stMpv(stMpv), .stMprv(stMprv),
    .stTsr(stTsr), .hsSpv(hsSpv), .hsVtsr(hsVtsr),
    .respValid(respValid), .excValid(excValid), .excCause(excCause),
    .newPriv(newPriv), .newVirt(newVirt), .retPc(retPc),
    .nxtMie(nxtMie), .nxtMpie(nxtMpie), .nxtSie(nxtSie), .nxtSpie(nxtSpie),
    .nxtSpp(nxtSpp), .nxtMpp(nxtMpp), .nxtMpv(nxtMpv), .nxtMprv(nxtMprv),
    .nxtSpv(nxtSpv)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  endtask

  task automatic clearState();
    curPriv = 2'd3; curVirt = 0; mepc = 32'h8000_0100; sepc = 32'h8000_0200;
    stMie = 0; stMpie = 0; stSie = 0; stSpie = 0; stSpp = 0; stMpp = 2'd0;
    stMpv = 0; stMprv = 0; stTsr = 0; hsSpv = 0; hsVtsr = 0;
  endtask

  // Pulse retValid for one cycle; outputs sampled at the following negedge
  task automatic issue(logic isMachine);
    @(negedge clk);
    retIsMachine = isMachine;
    retValid = 1'b1;
    @(negedge clk);
    retValid = 1'b0;
  endtask

  task automatic expectExc(string tag, logic [4:0] cause);
    chk({tag, " respValid"}, respValid, 1);
    chk({tag, " excValid"}, excValid, 1);
    chk({tag, " cause"}, excCause, cause);
  endtask

  task automatic t_reset();
    chk("R1 respValid", respValid, 0);
    chk("R1 excValid", excValid, 0);
    chk("R1 newPriv", newPriv, 3);
    chk("R1 newVirt", newVirt, 0);
  endtask

  task automatic t_sretLowPriv();
    clearState(); curPriv = 2'd0; stSie = 1; stSpie = 0; stMprv = 1; hsSpv = 1;
    issue(1'b0);
    expectExc("R2 sret at U", 5'd2);
    chk("R12 sie kept", nxtSie, 1);
    chk("R12 spie kept", nxtSpie, 0);
    chk("R12 mprv kept", nxtMprv, 1);
    chk("R12 spv kept", nxtSpv, 1);
    chk("R12 priv kept", newPriv, 0);
    chk("R12 retPc zero", retPc, 0);
  endtask

  task automatic t_sretTsr();
    clearState(); curPriv = 2'd1; stTsr = 1;
    issue(1'b0);
    expectExc("R3 tsr at S", 5'd2);
    clearState(); curPriv = 2'd3; stTsr = 1;
    issue(1'b0);
    chk("R3 tsr ignored at M", excValid, 0);
    chk("R3 tsr ignored at M pc", retPc, 32'h8000_0200);
  endtask

  task automatic t_sretVtsr();
    clearState(); curPriv = 2'd1; curVirt = 1; hsVtsr = 1;
    issue(1'b0);
    expectExc("R4 vtsr", 5'd22);
    clearState(); curPriv = 2'd1; curVirt = 1; hsVtsr = 1; stTsr = 1;
    issue(1'b0);
    expectExc("R3 tsr before vtsr", 5'd2);
  endtask

  task automatic t_misalign();
    clearState(); mepc = 32'h8000_0102; stMpie = 1;
    issue(1'b1);
    expectExc("R5 mret misaligned", 5'd0);
    chk("R12 mpie kept", nxtMpie, 1);
    clearState(); curPriv = 2'd1; sepc = 32'h8000_0201; stTsr = 1;
    issue(1'b0);
    expectExc("R5 misalign before tsr", 5'd0);
    clearState(); curPriv = 2'd0; sepc = 32'h8000_0203;
    issue(1'b0);
    expectExc("R5 priv before misalign", 5'd2);
  endtask

  task automatic t_sretOk();
    clearState(); curPriv = 2'd3; stSpp = 1; stSpie = 1; stSie = 0; stMprv = 1; hsSpv = 1;
    issue(1'b0);
    chk("R6 no exc", excValid, 0);
    chk("R6 priv", newPriv, 1);
    chk("R6 sie", nxtSie, 1);
    chk("R6 spie", nxtSpie, 1);
    chk("R6 spp", nxtSpp, 0);
    chk("R6 mprv", nxtMprv, 0);
    chk("R6 pc", retPc, 32'h8000_0200);
    chk("R7 virt from spv", newVirt, 1);
    chk("R7 spv cleared", nxtSpv, 0);
    clearState(); curPriv = 2'd1; stSpp = 0; stSpie = 0; stSie = 1;
    issue(1'b0);
    chk("R6 priv U", newPriv, 0);
    chk("R6 sie from spie", nxtSie, 0);
    chk("R7 virt stays off", newVirt, 0);
    clearState(); curPriv = 2'd1; curVirt = 1; hsSpv = 1; stSpp = 0;
    issue(1'b0);
    chk("R7 virt stays on", newVirt, 1);
    chk("R7 spv untouched", nxtSpv, 1);
  endtask

  task automatic t_mretLow();
    clearState(); curPriv = 2'd1; stMpie = 1; stMpp = 2'd1;
    issue(1'b1);
    expectExc("R8 mret at S", 5'd2);
    chk("R12 mpp kept", nxtMpp, 1);
    chk("R12 mie kept", nxtMie, 0);
  endtask

  task automatic t_mretOk();
    clearState(); stMpp = 2'd1; stMpie = 1; stMie = 0; stMpv = 1; stMprv = 1;
    issue(1'b1);
    chk("R9 no exc", excValid, 0);
    chk("R9 priv", newPriv, 1);
    chk("R9 mie", nxtMie, 1);
    chk("R9 mpie", nxtMpie, 1);
    chk("R9 mpp", nxtMpp, 0);
    chk("R9 mpv", nxtMpv, 0);
    chk("R9 pc", retPc, 32'h8000_0100);
    chk("R10 virt", newVirt, 1);
    chk("R11 mprv cleared", nxtMprv, 0);
    clearState(); stMpp = 2'd3; stMpv = 1; stMprv = 1; stMpie = 0; stMie = 1;
    issue(1'b1);
    chk("R10 virt off to M", newVirt, 0);
    chk("R11 mprv kept", nxtMprv, 1);
    chk("R9 mie from mpie", nxtMie, 0);
    chk("R9 priv M", newPriv, 3);
    clearState(); stMpp = 2'd0; stMpv = 0;
    issue(1'b1);
    chk("R10 virt off no mpv", newVirt, 0);
    chk("R9 priv U", newPriv, 0);
  endtask

  task automatic t_pulse();
    clearState();
    issue(1'b1);
    chk("R13 resp high", respValid, 1);
    chk("R13 exc low on success", excValid, 0);
    @(negedge clk);
    chk("R13 resp drops", respValid, 0);
  endtask

  initial begin
    clearState();
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_sretLowPriv();
    t_sretTsr();
    t_sretVtsr();
    t_misalign();
    t_sretOk();
    t_mretLow();
    t_mretOk();
    t_pulse();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule